// File: doc/BRIEF.md
# Binary Gradient Event Encoder

This block takes a raster stream of 8-bit greyscale pixels for a 128-column by 64-row frame, one pixel per accepted beat, left to right and top to bottom. For each pixel it looks at two neighbours: the pixel directly above and the pixel directly to the right. It takes the larger absolute difference between the pixel and either neighbour and divides it by the brightest of the three values. The result is compared against a threshold given as an 8-bit fraction. A pixel whose contrast is strictly larger than the threshold is a hit. Only hits leave the block, each as one coordinate word on a valid/ready output stream, so the output rate follows the activity of the scene. A small event queue absorbs bursts. When the queue is full, the block holds off the pixel input.

The block also keeps the binary map of the previous frame, one bit per pixel. It counts how many bits differ in the current frame. When the last pixel of a frame has been accepted, it raises a one-cycle end-of-frame pulse. With that pulse it raises a wake request if the count of changed pixels is strictly greater than a programmable activity limit. A downstream processor can stay asleep on quiet frames and wake only for frames with enough change.

Top module: `grad_event_encoder`

## Requirements
- R1: A pixel O with upper neighbour N and right neighbour E is a hit exactly when max(|E-O|, |N-O|) > (thr_frac * max(E, O, N)) >> 8, with thr_frac unsigned. A uniform area therefore never produces a hit, even with thr_frac = 0.
- R2: Pixels in row 0 and pixels in column 127 are never hits and never produce events.
- R3: Each hit produces exactly one event word, in raster order. The column goes in bits [6:0], bit 7 is 0 and the row goes in bits [13:8]. Pixels that are not hits produce no word.
- R4: While ev_valid is high and ev_ready is low, ev_valid and ev_word hold. pix_ready is low only while the event queue is full, and no hit is lost while the input is held off.
- R5: frame_end is high for exactly one cycle, in the cycle right after the clock edge that accepts the last pixel (column 127, row 63) of a frame.
- R6: wake_req is high only together with frame_end. It is high exactly when the number of pixels whose binary value differs from the previous frame is strictly greater than act_limit.
- R7: The change count compares each pixel with its value in the previous frame. After reset the stored map is all zero, and a frame identical to the one before it gives a count of 0.
- R8: After reset, ev_valid, frame_end and wake_req are 0 and pix_ready is 1.
- R9: Frames follow one another with no gap or marker. The beat after the last pixel of a frame is pixel (0,0) of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Pixel beat offered |
| pix_ready | output | 1 | Pixel beat can be taken |
| pix_data | input | 8 | Greyscale pixel value |
| thr_frac | input | 8 | Contrast threshold as a fraction of 256 |
| act_limit | input | 14 | Change count that must be exceeded to wake |
| ev_valid | output | 1 | Event word available |
| ev_ready | input | 1 | Event word taken |
| ev_word | output | 14 | Event coordinates: column [6:0], row [13:8] |
| frame_end | output | 1 | One-cycle pulse after the last pixel of a frame |
| wake_req | output | 1 | Activity above limit, valid with frame_end |

## Verification
The interesting overlap is between the stalled event queue and the pixel input. A hit can arrive in the same cycle that the queue drains a word or fills its last slot. The last hit of a frame can also be pushed in the same cycle that the end-of-frame pulse and wake decision are registered. The bench forces both by holding ev_ready low in long periodic stretches during a busy frame, so that pix_ready drops and releases many times, frame end included. It then requires that every expected coordinate arrives in order, that the pulse appears one cycle after the final accepted beat, and that the wake value matches a change count that the bench computes itself.

// File: rtl/gev_pkg.sv
package gev_pkg;

    localparam int PIX_W  = 8;
    localparam int FRAC_W = 8;

    typedef logic [PIX_W-1:0]  pix_t;
    typedef logic [FRAC_W-1:0] frac_t;

    typedef struct packed {
        pix_t ctr;
        pix_t up;
        pix_t rt;
    } nbhd_t;

    function automatic pix_t abs_gap(pix_t a, pix_t b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    function automatic pix_t larger(pix_t a, pix_t b);
        return (a > b) ? a : b;
    endfunction

    // Divider-free contrast test: gap > frac * peak / 2^FRAC_W
    function automatic logic contrast_hit(nbhd_t w, frac_t frac);
        pix_t gap;
        pix_t peak;
        logic [PIX_W+FRAC_W-1:0] scaled;
        gap    = larger(abs_gap(w.rt, w.ctr), abs_gap(w.up, w.ctr));
        peak   = larger(larger(w.rt, w.ctr), w.up);
        scaled = {{FRAC_W{1'b0}}, peak} * {{PIX_W{1'b0}}, frac};
        return gap > scaled[PIX_W+FRAC_W-1:FRAC_W];
    endfunction

endpackage

// File: rtl/gev_window.sv
module gev_window
    import gev_pkg::*;
#(
    parameter int COLS = 128,
    localparam int X_W = $clog2(COLS)
) (
    input  logic           clk,
    input  logic           accept,
    input  logic [X_W-1:0] col,
    input  pix_t           pix_in,
    output pix_t           ctr_q,
    output pix_t           up_q
);

    pix_t line_mem [COLS];

    // The row buffer slot is read before it is overwritten, so up_q holds
    // the pixel above the one now held in ctr_q.
    always_ff @(posedge clk) begin
        if (accept) begin
            up_q          <= line_mem[col];
            line_mem[col] <= pix_in;
            ctr_q         <= pix_in;
        end
    end

endmodule

// File: rtl/gev_activity.sv
module gev_activity #(
    parameter int COLS = 128,
    parameter int ROWS = 64,
    localparam int X_W   = $clog2(COLS),
    localparam int Y_W   = $clog2(ROWS),
    localparam int CNT_W = $clog2(COLS * ROWS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [X_W-1:0]   col,
    input  logic [Y_W-1:0]   row,
    input  logic             bit_in,
    input  logic             last,
    input  logic [CNT_W-1:0] limit,
    output logic             frame_end,
    output logic             wake_req
);

    logic [COLS-1:0] bitmap [ROWS];
    logic [CNT_W-1:0] tally;
    logic [CNT_W-1:0] tally_next;
    logic             flipped;

    assign flipped    = step && (bit_in != bitmap[row][col]);
    assign tally_next = tally + CNT_W'(flipped);

    always_ff @(posedge clk) begin
        if (rst) begin
            tally     <= '0;
            frame_end <= 1'b0;
            wake_req  <= 1'b0;
            for (int r = 0; r < ROWS; r++) begin
                bitmap[r] <= '0;
            end
        end else begin
            frame_end <= 1'b0;
            wake_req  <= 1'b0;
            if (step) begin
                bitmap[row][col] <= bit_in;
                if (last) begin
                    tally     <= '0;
                    frame_end <= 1'b1;
                    wake_req  <= tally_next > limit;
                end else begin
                    tally <= tally_next;
                end
            end
        end
    end

    // R5: the end-of-frame marker never lasts two cycles
    p_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> !frame_end);

    // R6: a wake request only travels with the frame marker
    p_wake_r6: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> frame_end);

endmodule

// File: rtl/gev_fifo.sv
module gev_fifo #(
    parameter int W     = 14,
    parameter int DEPTH = 8,
    localparam int A_W = $clog2(DEPTH),
    localparam int C_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         nonempty,
    output logic         full
);

    logic [W-1:0]   store [DEPTH];
    logic [A_W-1:0] wr_ptr;
    logic [A_W-1:0] rd_ptr;
    logic [C_W-1:0] fill;

    assign dout     = store[rd_ptr];
    assign nonempty = fill != '0;
    assign full     = fill == C_W'(DEPTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) begin
                store[wr_ptr] <= din;
                wr_ptr <= (wr_ptr == A_W'(DEPTH - 1)) ? '0 : wr_ptr + A_W'(1);
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == A_W'(DEPTH - 1)) ? '0 : rd_ptr + A_W'(1);
            end
            fill <= fill + C_W'(push) - C_W'(pop);
        end
    end

    // R4: a hit is never pushed into a full queue
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    // R4: nothing is taken from an empty queue
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
        pop |-> nonempty);

endmodule

// File: rtl/grad_event_encoder.sv
module grad_event_encoder
    import gev_pkg::*;
#(
    parameter int COLS       = 128,
    parameter int ROWS       = 64,
    parameter int FIFO_DEPTH = 8,
    localparam int X_W   = $clog2(COLS),
    localparam int Y_W   = $clog2(ROWS),
    localparam int Y_LSB = X_W + 1,
    localparam int EV_W  = Y_LSB + Y_W,
    localparam int CNT_W = $clog2(COLS * ROWS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_valid,
    output logic             pix_ready,
    input  logic [PIX_W-1:0] pix_data,
    input  logic [FRAC_W-1:0] thr_frac,
    input  logic [CNT_W-1:0] act_limit,
    output logic             ev_valid,
    input  logic             ev_ready,
    output logic [EV_W-1:0]  ev_word,
    output logic             frame_end,
    output logic             wake_req
);

    logic           accept;
    logic [X_W-1:0] col;
    logic [Y_W-1:0] row;
    logic [X_W-1:0] judged_col;
    logic           step;
    logic           last_beat;
    logic           hit;
    logic           q_full;
    pix_t           ctr_q;
    pix_t           up_q;
    nbhd_t          win;
    logic [EV_W-1:0] ev_in;

    assign accept    = pix_valid && pix_ready;
    assign pix_ready = !q_full;

    // Raster position of the incoming beat; wraps to (0,0) after a frame.
    always_ff @(posedge clk) begin
        if (rst) begin
            col <= '0;
            row <= '0;
        end else if (accept) begin
            if (col == X_W'(COLS - 1)) begin
                col <= '0;
                row <= (row == Y_W'(ROWS - 1)) ? '0 : row + Y_W'(1);
            end else begin
                col <= col + X_W'(1);
            end
        end
    end

    gev_window #(.COLS(COLS)) u_window (
        .clk    (clk),
        .accept (accept),
        .col    (col),
        .pix_in (pix_data),
        .ctr_q  (ctr_q),
        .up_q   (up_q)
    );

    // The pixel judged is the one left of the incoming beat, whose right
    // neighbour has just arrived; the last column is therefore never judged.
    assign win        = '{ctr: ctr_q, up: up_q, rt: pix_data};
    assign judged_col = col - X_W'(1);
    assign step       = accept && (col != '0);
    assign last_beat  = (col == X_W'(COLS - 1)) && (row == Y_W'(ROWS - 1));
    assign hit        = step && (row != '0) && contrast_hit(win, thr_frac);

    always_comb begin
        ev_in = '0;
        ev_in[X_W-1:0]       = judged_col;
        ev_in[EV_W-1:Y_LSB]  = row;
    end

    gev_fifo #(.W(EV_W), .DEPTH(FIFO_DEPTH)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .push     (hit),
        .din      (ev_in),
        .pop      (ev_valid && ev_ready),
        .dout     (ev_word),
        .nonempty (ev_valid),
        .full     (q_full)
    );

    gev_activity #(.COLS(COLS), .ROWS(ROWS)) u_activity (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .col       (judged_col),
        .row       (row),
        .bit_in    (hit),
        .last      (last_beat),
        .limit     (act_limit),
        .frame_end (frame_end),
        .wake_req  (wake_req)
    );

    // R4: an offered word is held until taken
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        ev_valid && !ev_ready |=> ev_valid && $stable(ev_word));

    // R4: the input is held off only when words are waiting
    p_stall_r4: assert property (@(posedge clk) disable iff (rst)
        !pix_ready |-> ev_valid);

    // R2 and R3: no word names row 0 or the last column, and the spare bit is clear
    p_edges_r2: assert property (@(posedge clk) disable iff (rst)
        ev_valid |-> (ev_word[EV_W-1:Y_LSB] != '0)
                  && (ev_word[X_W-1:0] != X_W'(COLS - 1))
                  && (ev_word[Y_LSB-1:X_W] == 1'b0));

    // R5: the frame marker follows an accepted beat
    p_frame_end_r5: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> $past(accept));

endmodule

// File: tb/test_grad_event_encoder.sv
module test_grad_event_encoder;

    localparam int CLK_PERIOD = 10;
    localparam int COLS = 128;
    localparam int ROWS = 64;

    logic        clk;
    logic        rst;
    logic        pix_valid;
    logic        pix_ready;
    logic [7:0]  pix_data;
    logic [7:0]  thr_frac;
    logic [13:0] act_limit;
    logic        ev_valid;
    logic        ev_ready;
    logic [13:0] ev_word;
    logic        frame_end;
    logic        wake_req;

    grad_event_encoder #(.COLS(COLS), .ROWS(ROWS), .FIFO_DEPTH(8)) i_grad_event_encoder (
        .clk       (clk),
        .rst       (rst),
        .pix_valid (pix_valid),
        .pix_ready (pix_ready),
        .pix_data  (pix_data),
        .thr_frac  (thr_frac),
        .act_limit (act_limit),
        .ev_valid  (ev_valid),
        .ev_ready  (ev_ready),
        .ev_word   (ev_word),
        .frame_end (frame_end),
        .wake_req  (wake_req)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int rdy_mode = 0;
    bit saw_stall = 0;
    int fe_seen = 0;
    logic [13:0] got [$];
    bit prev_map [ROWS][COLS];

    always @(posedge clk) cyc++;

    // Output side: set ready, then record the word that the next edge takes.
    always @(negedge clk) begin
        case (rdy_mode)
            0: ev_ready = 1'b1;
            1: ev_ready = (cyc % 16) >= 10;
            default: ev_ready = 1'b0;
        endcase
        if (!rst) begin
            if (ev_valid && ev_ready) got.push_back(ev_word);
            if (!pix_ready) saw_stall = 1;
            if (frame_end) fe_seen++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int pv(int kind, int x, int y);
        case (kind)
            0: return 100;
            1: return ((x * 7 + y * 13) ^ (x * y)) & 255;
            2: return (((x / 8) + (y / 8)) % 2 == 1) ? 200 : 30 + (x % 3);
            default: return (x * x + 3 * y) & 255;
        endcase
    endfunction

    function automatic bit model_hit(int o, int n, int e, int thr);
        int de, dn, md, mp;
        de = (e > o) ? e - o : o - e;
        dn = (n > o) ? n - o : o - n;
        md = (de > dn) ? de : dn;
        mp = (e > o) ? e : o;
        if (n > mp) mp = n;
        return md > ((thr * mp) / 256);
    endfunction

    function automatic bit model_bit(int kind, int x, int y, int thr);
        if (y == 0 || x == COLS - 1) return 0;
        return model_hit(pv(kind, x, y), pv(kind, x, y - 1), pv(kind, x + 1, y), thr);
    endfunction

    function automatic int count_changes(int kind, int thr);
        int c = 0;
        for (int y = 0; y < ROWS; y++)
            for (int x = 0; x < COLS; x++)
                if (model_bit(kind, x, y, thr) != prev_map[y][x]) c++;
        return c;
    endfunction

    task automatic run_frame(input int kind, input int thr, input int limit,
                             input int mode, input string req);
        logic [13:0] exp [$];
        int chg = 0;
        int fe0;
        int bad = 0;
        int first_bad = -1;
        int edge_words = 0;
        int waited = 0;
        for (int y = 0; y < ROWS; y++)
            for (int x = 0; x < COLS; x++) begin
                bit b = model_bit(kind, x, y, thr);
                if (b) exp.push_back(14'((y << 8) | x));
                if (b != prev_map[y][x]) chg++;
                prev_map[y][x] = b;
            end
        @(negedge clk);
        thr_frac  = 8'(thr);
        act_limit = 14'(limit);
        rdy_mode  = mode;
        got.delete();
        fe0 = fe_seen;
        for (int y = 0; y < ROWS; y++)
            for (int x = 0; x < COLS; x++) begin
                pix_valid = 1'b1;
                pix_data  = 8'(pv(kind, x, y));
                while (!pix_ready) @(negedge clk);
                @(negedge clk);
            end
        pix_valid = 1'b0;
        chk(frame_end == 1'b1, "R5", "frame_end after last beat", int'(frame_end), 1);
        chk(wake_req == (chg > limit), "R6", "wake_req at frame end",
            int'(wake_req), int'(chg > limit));
        @(negedge clk);
        chk(frame_end == 1'b0, "R5", "frame_end pulse width", int'(frame_end), 0);
        chk(fe_seen - fe0 == 1, "R5", "frame_end pulses in frame", fe_seen - fe0, 1);
        rdy_mode = 0;
        while (got.size() < exp.size() && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        repeat (4) @(negedge clk);
        chk(got.size() == exp.size(), req, "event count", got.size(), exp.size());
        for (int i = 0; i < exp.size() && i < got.size(); i++) begin
            if (got[i] != exp[i]) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
        end
        if (first_bad >= 0)
            chk(0, req, "event word", int'(got[first_bad]), int'(exp[first_bad]));
        else
            chk(1, req, "event words", 0, 0);
        foreach (got[i])
            if (got[i][13:8] == 0 || got[i][6:0] == COLS - 1 || got[i][7]) edge_words++;
        chk(edge_words == 0, "R2", "words on edge rows or columns", edge_words, 0);
    endtask

    task automatic t_reset;
        pix_valid = 1'b0;
        pix_data  = 8'd0;
        thr_frac  = 8'd0;
        act_limit = 14'd0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ev_valid == 1'b0, "R8", "ev_valid after reset", int'(ev_valid), 0);
        chk(frame_end == 1'b0, "R8", "frame_end after reset", int'(frame_end), 0);
        chk(wake_req == 1'b0, "R8", "wake_req after reset", int'(wake_req), 0);
        chk(pix_ready == 1'b1, "R8", "pix_ready after reset", int'(pix_ready), 1);
    endtask

    task automatic t_flat;
        // R1: uniform scene gives no hit at zero threshold; R7: map starts empty
        run_frame(0, 0, 0, 0, "R1 R7");
    endtask

    task automatic t_pattern;
        // R1 and R3 on a busy texture; change count is large so R6 wakes
        run_frame(1, 64, 10, 0, "R1 R3");
    endtask

    task automatic t_repeat;
        // R7: identical frame changes nothing; R9: frames continue after wrap
        run_frame(1, 64, 0, 0, "R7 R9");
    endtask

    task automatic t_backpressure;
        saw_stall = 0;
        run_frame(3, 32, 8000, 1, "R4");
        chk(saw_stall == 1, "R4", "pix_ready dropped under stall", int'(saw_stall), 1);
    endtask

    task automatic t_sensitivity;
        run_frame(2, 0, 8000, 0, "R1");
        run_frame(2, 255, 8000, 0, "R1");
    endtask

    task automatic t_limit;
        int c;
        run_frame(1, 64, 8000, 0, "R6");
        c = count_changes(3, 64);
        run_frame(3, 64, c, 0, "R6");
        c = count_changes(1, 64);
        chk(c > 0, "R6", "model change count positive", c, 1);
        run_frame(1, 64, c - 1, 0, "R6");
    endtask

    initial begin
        rst = 1'b1;
        ev_ready = 1'b1;
        t_reset();
        t_flat();
        t_pattern();
        t_repeat();
        t_backpressure();
        t_sensitivity();
        t_limit();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R4 watchdog expired: actual %0d expected %0d", cyc, 190000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule